// File: doc/BRIEF.md
# I2C Serial Clock Period Generator

This block produces the serial clock of an I2C controller from two pairs of programmable counts, one pair for standard-mode timing and one for fast-mode timing. A two-bit speed field picks the active pair. While the block is enabled, the clock alternates between two phases. In the low phase the block pulls the line low. In the high phase it releases the line. Each phase length comes from the selected count plus a fixed number of overhead cycles.

The low phase is timed from the cycle in which the block itself starts pulling the line down. The high phase carries eight overhead cycles on top of the programmed count: one to release the line, four to synchronise the returning level, and three of tail. The high-phase counter only advances while the sampled line reads high. A target that holds the line low therefore stretches the clock without any extra logic.

Two single-cycle strobes feed the neighbouring bit engine. One marks the first cycle of every low phase, so data may change there. The other marks the middle of the high phase, so data may be sampled there. The counts are meant to be changed only while the block is disabled. The selected pair is captured at the start of each phase.

Top module: `sclGen`

## Requirements
- R1: While `enable` is low (and in reset) the line is released (`sclDriveLow`=0), both strobes stay 0, and the phase counter is held at zero, so the first low phase after re-enabling has its full programmed length.
- R2: The clock edge after `enable` is first sampled high starts a low phase. `fallStb` is 1 exactly on the first cycle of every low phase and at no other time.
- R3: A low phase lasts the selected low count plus 1 cycles, from count 0 (1 cycle) up to the maximum count.
- R4: With the sampled line high throughout, a high phase lasts the selected high count plus 8 cycles, from count 0 (8 cycles) up to the maximum count.
- R5: `speedField` value 2'b01 selects the standard pair. Every other value (2'b00, 2'b10, 2'b11) selects the fast pair. The choice is captured at the clock edge that starts a phase, so changing the field mid-phase affects only later phases.
- R6: Each clock edge in the high phase at which `sclIn` reads low does not advance the count. The high phase grows by exactly that many cycles.
- R7: `midStb` pulses for one cycle per high phase, in the cycle where the high-phase count equals floor((high count + 8)/2) and `sclIn` is high. With no stretching, this is cycle index floor((high count + 8)/2), counting from 0 at the first released cycle.
- R8: Dropping `enable` during either phase releases the line from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the clock generator |
| speedField | input | 2 | 2'b01 standard pair, otherwise fast pair |
| stdHighCnt | input | CNT_W | Standard-mode high count |
| stdLowCnt | input | CNT_W | Standard-mode low count |
| fastHighCnt | input | CNT_W | Fast-mode high count |
| fastLowCnt | input | CNT_W | Fast-mode low count |
| sclIn | input | 1 | Sampled level of the clock line |
| sclDriveLow | output | 1 | 1 pulls the clock line low |
| fallStb | output | 1 | First cycle of a low phase |
| midStb | output | 1 | Middle of a high phase |

## Verification
The bench builds the block with CNT_W = 6. This narrow width puts both the zero count and the all-ones count of 63 within a short run, so low phases of 1 and 64 cycles and high phases of 8 and 71 cycles are measured directly. Small mid-range counts for the two pairs keep the two modes distinguishable by phase length, both when the speed field changes mid-phase and when a target stretches the clock. The mid-high strobe position is checked with and without stretching.

// File: rtl/sclGenPkg.sv
package sclGenPkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;
    logic inc;
    logic loadLow;
    logic loadHigh;
  } cntCtl_t;

  // high-phase overhead: release, level synchronisation, tail
  localparam int HI_OVH_RELEASE = 1;
  localparam int HI_OVH_SYNC    = 4;
  localparam int HI_OVH_TAIL    = 3;
  localparam int HI_OVH         = HI_OVH_RELEASE + HI_OVH_SYNC + HI_OVH_TAIL;
  // low phase: count starts in the cycle the line is pulled
  localparam int LO_OVH         = 1;

  localparam logic [1:0] SPEED_STD = 2'b01;
  localparam int MODE_STD  = 0;
  localparam int MODE_FAST = 1;
  localparam int NMODE     = 2;

endpackage

// File: rtl/sclGenCtrl.sv
module sclGenCtrl
  import sclGenPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    sclIn,
  input  logic    cntDone,
  output phase_e  phase,
  output cntCtl_t ctl
);

  phase_e phaseNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end

  always_comb begin
    phaseNxt = phase;
    ctl      = '0;
    unique case (phase)
      PH_IDLE: begin
        ctl.clr = 1'b1;
        if (enable) begin
          phaseNxt    = PH_LOW;
          ctl.clr     = 1'b0;
          ctl.loadLow = 1'b1;
        end
      end
      PH_LOW: begin
        if (!enable) begin
          phaseNxt = PH_IDLE;
          ctl.clr  = 1'b1;
        end else if (cntDone) begin
          phaseNxt     = PH_HIGH;
          ctl.loadHigh = 1'b1;
        end else begin
          ctl.inc = 1'b1;
        end
      end
      PH_HIGH: begin
        if (!enable) begin
          phaseNxt = PH_IDLE;
          ctl.clr  = 1'b1;
        end else if (sclIn) begin
          if (cntDone) begin
            phaseNxt    = PH_LOW;
            ctl.loadLow = 1'b1;
          end else begin
            ctl.inc = 1'b1;
          end
        end
      end
      default: begin
        phaseNxt = PH_IDLE;
        ctl.clr  = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/sclGenDatapath.sv
module sclGenDatapath
  import sclGenPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCtl_t          ctl,
  input  logic [1:0]       speedField,
  input  logic [CNT_W-1:0] stdHighCnt,
  input  logic [CNT_W-1:0] stdLowCnt,
  input  logic [CNT_W-1:0] fastHighCnt,
  input  logic [CNT_W-1:0] fastLowCnt,
  output logic             cntDone,
  output logic             cntMid,
  output logic             cntZero
);

  // one extra bit so count plus overhead never wraps
  localparam int CW = CNT_W + 1;

  logic [CNT_W-1:0] hiCfg [NMODE];
  logic [CNT_W-1:0] loCfg [NMODE];
  logic [CW-1:0]    hiTgt [NMODE];
  logic [CW-1:0]    loTgt [NMODE];
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    tgt;
  logic             modeSel;

  assign hiCfg[MODE_STD]  = stdHighCnt;
  assign loCfg[MODE_STD]  = stdLowCnt;
  assign hiCfg[MODE_FAST] = fastHighCnt;
  assign loCfg[MODE_FAST] = fastLowCnt;

  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    assign loTgt[m] = CW'(loCfg[m]) + CW'(LO_OVH);
    assign hiTgt[m] = CW'(hiCfg[m]) + CW'(HI_OVH);
  end

  assign modeSel = (speedField == SPEED_STD) ? 1'b0 : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      tgt <= '0;
    end else if (ctl.clr) begin
      cnt <= '0;
      tgt <= '0;
    end else if (ctl.loadLow) begin
      cnt <= '0;
      tgt <= loTgt[modeSel];
    end else if (ctl.loadHigh) begin
      cnt <= '0;
      tgt <= hiTgt[modeSel];
    end else if (ctl.inc) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign cntDone = (cnt == tgt - CW'(1));
  assign cntMid  = (cnt == (tgt >> 1));
  assign cntZero = (cnt == '0);

endmodule

// File: rtl/sclGen.sv
module sclGen
  import sclGenPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [1:0]       speedField,
  input  logic [CNT_W-1:0] stdHighCnt,
  input  logic [CNT_W-1:0] stdLowCnt,
  input  logic [CNT_W-1:0] fastHighCnt,
  input  logic [CNT_W-1:0] fastLowCnt,
  input  logic             sclIn,
  output logic             sclDriveLow,
  output logic             fallStb,
  output logic             midStb
);

  phase_e  phase;
  cntCtl_t ctl;
  logic    cntDone;
  logic    cntMid;
  logic    cntZero;

  sclGenCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .sclIn   (sclIn),
    .cntDone (cntDone),
    .phase   (phase),
    .ctl     (ctl)
  );

  sclGenDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .speedField  (speedField),
    .stdHighCnt  (stdHighCnt),
    .stdLowCnt   (stdLowCnt),
    .fastHighCnt (fastHighCnt),
    .fastLowCnt  (fastLowCnt),
    .cntDone     (cntDone),
    .cntMid      (cntMid),
    .cntZero     (cntZero)
  );

  assign sclDriveLow = (phase == PH_LOW);
  assign fallStb     = (phase == PH_LOW) && cntZero;
  assign midStb      = (phase == PH_HIGH) && sclIn && cntMid;

endmodule

// File: rtl/sclGenChk.sv
module sclGenChk
  import sclGenPkg::*;
(
  input logic   clk,
  input logic   rstN,
  input logic   enable,
  input logic   sclIn,
  input logic   sclDriveLow,
  input logic   fallStb,
  input logic   midStb,
  input phase_e phase
);

  AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclDriveLow && !fallStb && !midStb)); // R8

  AST_FALL_ON_PULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> fallStb); // R2

  AST_FALL_ONLY_LOW: assert property (@(posedge clk) disable iff (!rstN)
    fallStb |-> sclDriveLow); // R2

  AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH && !sclIn) |=> !sclDriveLow); // R6

  AST_HIGH_MIN_TWO: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclDriveLow) |=> !sclDriveLow); // R4

  AST_MID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    midStb |=> !midStb); // R7

endmodule

bind sclGen sclGenChk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .sclIn       (sclIn),
  .sclDriveLow (sclDriveLow),
  .fallStb     (fallStb),
  .midStb      (midStb),
  .phase       (phase)
);

// File: tb/sclGen_tb.sv
module sclGen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 6;
  localparam int WATCHDOG   = 100000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic [1:0]       speedField = 2'b01;
  logic [CNT_W-1:0] stdHighCnt = 6'd3;
  logic [CNT_W-1:0] stdLowCnt = 6'd5;
  logic [CNT_W-1:0] fastHighCnt = 6'd1;
  logic [CNT_W-1:0] fastLowCnt = 6'd2;
  logic             stretch = 1'b0;
  logic             sclIn;
  logic             sclDriveLow, fallStb, midStb;

  assign sclIn = !sclDriveLow && !stretch;

  sclGen #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .speedField(speedField),
    .stdHighCnt(stdHighCnt), .stdLowCnt(stdLowCnt),
    .fastHighCnt(fastHighCnt), .fastLowCnt(fastLowCnt),
    .sclIn(sclIn), .sclDriveLow(sclDriveLow), .fallStb(fallStb), .midStb(midStb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    nChecks = 0;
  int    nErrors = 0;
  string curReq = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 low, 2 high
  int mPh = 0, mCnt = 0, mTgt = 0;

  function automatic int lowLen();
    return (speedField == 2'b01) ? int'(stdLowCnt) + 1 : int'(fastLowCnt) + 1;
  endfunction
  function automatic int highLen();
    return (speedField == 2'b01) ? int'(stdHighCnt) + 8 : int'(fastHighCnt) + 8;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mCnt = 0; mTgt = 0;
    end else begin
      bit lineHigh;
      lineHigh = (mPh != 1) && !stretch;
      if (mPh == 0) begin
        if (enable) begin mPh = 1; mCnt = 0; mTgt = lowLen(); end
      end else if (!enable) begin
        mPh = 0; mCnt = 0; mTgt = 0;
      end else if (mPh == 1) begin
        if (mCnt + 1 == mTgt) begin mPh = 2; mCnt = 0; mTgt = highLen(); end
        else mCnt++;
      end else if (lineHigh) begin
        if (mCnt + 1 == mTgt) begin mPh = 1; mCnt = 0; mTgt = lowLen(); end
        else mCnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      bit eLow, eFall, eMid;
      eLow  = (mPh == 1);
      eFall = eLow && (mCnt == 0);
      eMid  = (mPh == 2) && sclIn && (mCnt == mTgt / 2);
      check(sclDriveLow == eLow, curReq, "sclDriveLow per cycle", int'(sclDriveLow), int'(eLow));
      check(fallStb == eFall, curReq, "fallStb per cycle", int'(fallStb), int'(eFall));
      check(midStb == eMid, curReq, "midStb per cycle", int'(midStb), int'(eMid));
    end
  end

  // phase length monitor
  int runLen = 0, stretchSeen = 0, midCnt = 0, midOff = -1;
  int lastLow = 0, lastHigh = 0, lastStretch = 0, lastMidOff = 0, lastMidCnt = 0;
  int lowDone = 0, highDone = 0;
  bit runValid = 0, prevLow = 0;

  always @(posedge clk) if (!sclDriveLow && stretch) stretchSeen++;

  always @(negedge clk) begin
    if (!rstN || !enable) begin
      runValid = 0; runLen = 0; prevLow = sclDriveLow;
    end else begin
      if (sclDriveLow != prevLow) begin
        if (runValid) begin
          if (prevLow) begin lastLow = runLen; lowDone++; end
          else begin
            lastHigh = runLen; lastStretch = stretchSeen;
            lastMidOff = midOff; lastMidCnt = midCnt; highDone++;
          end
        end
        runValid = 1; runLen = 0; stretchSeen = 0; midCnt = 0; midOff = -1;
      end
      if (midStb) begin midCnt++; midOff = runLen; end
      runLen++;
      prevLow = sclDriveLow;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask
  task automatic waitHighEnds(input int n);
    int base = highDone;
    wait (highDone >= base + n);
  endtask
  task automatic waitLowEnds(input int n);
    int base = lowDone;
    wait (lowDone >= base + n);
  endtask
  task automatic restart(input logic [1:0] sp);
    tick(1); enable = 1'b0;
    tick(3); speedField = sp;
    tick(1); enable = 1'b1;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG) begin @(posedge clk); cyc++; end
    nErrors++;
    nChecks++;
    $display("FAIL watchdog expired: actual=%0d expected=0", cyc);
    finishRun();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(!sclDriveLow && !fallStb && !midStb, "R1", "outputs in reset", int'(sclDriveLow), 0);
    tick(1); rstN = 1'b1;
    tick(4);
    @(negedge clk);
    check(!sclDriveLow && !fallStb && !midStb, "R1", "outputs while disabled", int'(sclDriveLow), 0);

    // R2 start of the first low phase
    curReq = "R2";
    tick(1); enable = 1'b1;
    @(negedge clk);
    check(sclDriveLow == 1'b0, "R2", "no pull before the enable edge", int'(sclDriveLow), 0);
    @(negedge clk);
    check(sclDriveLow && fallStb, "R2", "first low cycle with fallStb", int'(fallStb), 1);

    // R3 R4 R7 standard pair
    curReq = "R3";
    waitHighEnds(2);
    check(lastLow == 6, "R3", "standard low length", lastLow, 6);
    check(lastHigh == 11, "R4", "standard high length", lastHigh, 11);
    check(lastMidOff == 5, "R7", "mid strobe position", lastMidOff, 5);
    check(lastMidCnt == 1, "R7", "mid strobes per high", lastMidCnt, 1);

    // R5 fast pair for every non-standard code
    curReq = "R5";
    restart(2'b10);
    waitHighEnds(2);
    check(lastLow == 3, "R5", "fast low length code 10", lastLow, 3);
    check(lastHigh == 9, "R5", "fast high length code 10", lastHigh, 9);
    check(lastMidOff == 4, "R7", "fast mid position", lastMidOff, 4);
    restart(2'b11);
    waitHighEnds(2);
    check(lastLow == 3 && lastHigh == 9, "R5", "fast pair code 11", lastHigh, 9);
    restart(2'b00);
    waitHighEnds(2);
    check(lastLow == 3 && lastHigh == 9, "R5", "fast pair code 00", lastLow, 3);

    // R5 change captured only at phase start
    restart(2'b01);
    waitHighEnds(1);
    tick(1); speedField = 2'b10;
    waitLowEnds(1);
    check(lastLow == 6, "R5", "low keeps standard after mid-phase change", lastLow, 6);
    waitHighEnds(1);
    check(lastHigh == 9, "R5", "next high uses fast pair", lastHigh, 9);

    // R6 clock stretching
    curReq = "R6";
    restart(2'b01);
    waitHighEnds(1);
    waitLowEnds(1);
    tick(1); stretch = 1'b1;
    tick(5); stretch = 1'b0;
    waitHighEnds(1);
    check(lastStretch == 5, "R6", "stretched edges seen", lastStretch, 5);
    check(lastHigh == 16, "R6", "stretched high length", lastHigh, 16);
    check(lastMidOff == 10, "R7", "mid position after stretch", lastMidOff, 10);
    check(lastMidCnt == 1, "R7", "single mid strobe with stretch", lastMidCnt, 1);

    // R8 disable during low, R1 idle and full restart
    curReq = "R8";
    waitHighEnds(1);
    tick(1); enable = 1'b0;
    @(negedge clk);
    check(sclDriveLow == 1'b1, "R8", "still low before edge", int'(sclDriveLow), 1);
    @(negedge clk);
    check(sclDriveLow == 1'b0, "R8", "released after disable", int'(sclDriveLow), 0);
    curReq = "R1";
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!sclDriveLow && !fallStb && !midStb, "R1", "idle outputs", int'(fallStb) + int'(midStb), 0);
    end
    tick(1); enable = 1'b1;
    waitLowEnds(1);
    check(lastLow == 6, "R1", "full low after re-enable", lastLow, 6);

    // R8 disable during high
    curReq = "R8";
    tick(2); enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(sclDriveLow == 1'b0 && !midStb, "R8", "released after disable in high", int'(sclDriveLow), 0);

    // R3 R4 boundary counts
    curReq = "R3";
    tick(2); stdLowCnt = 6'd0; stdHighCnt = 6'd0;
    restart(2'b01);
    waitHighEnds(2);
    check(lastLow == 1, "R3", "zero low count", lastLow, 1);
    check(lastHigh == 8, "R4", "zero high count", lastHigh, 8);
    check(lastMidOff == 4, "R7", "mid at zero high count", lastMidOff, 4);
    tick(1); enable = 1'b0;
    tick(2); stdLowCnt = 6'd63; stdHighCnt = 6'd63;
    restart(2'b01);
    waitHighEnds(2);
    check(lastLow == 64, "R3", "max low count", lastLow, 64);
    check(lastHigh == 71, "R4", "max high count", lastHigh, 71);
    check(lastMidOff == 35, "R7", "mid at max high count", lastMidOff, 35);

    tick(1); enable = 1'b0;
    tick(3);
    finishRun();
  end

endmodule